// File: doc/BRIEF.md
# Banked Memory Mapping Unit

This unit translates a 16-bit CPU address into an address in a larger physical store. The CPU space is split into eight windows of 8 KB. The top three address bits pick a window, and each window holds a 6-bit block number. The physical address is the window's block number joined to the low 13 CPU address bits, which gives 19 bits.

Software reaches the eight block registers through two 8-bit I/O ports. The index port picks a window. The data port reads or writes the block number of the window that the index currently picks. The index steps forward by one after every data-port access, so a run of data-port writes loads consecutive windows.

For every memory cycle the unit also produces:
- a region code that says what kind of store the block belongs to;
- a wait-state count that depends on the region and on whether the cycle is an opcode fetch;
- a fault flag for opcode fetches from video memory;
- a stall that holds video accesses until the display is in blanking.

One block number is left unmapped. Reads from it return all ones, and writes to it are dropped.

Top module: `bank_map_unit`

## Requirements
- R1: After reset the index is 0. Windows 0 and 1 hold blocks 34h and 35h. Every other window n holds block n.
- R2: A write to the index port (io_port=0) stores io_wdata[2:0] as the index and ignores bits 7:3.
- R3: A write to the data port (io_port=1) stores io_wdata[5:0] in the selected window. io_rdata always shows {2'b00, block} of the selected window.
- R4: Each data-port read or write advances the index by one, wrapping from 7 to 0. A cycle that has both strobes active advances it once. Index-port writes do not advance it.
- R5: For each access, phys_block is the block held by window mem_addr[15:13], and phys_addr = {phys_block, mem_addr[12:0]}.
- R6: region is decoded from the block number as follows:
  - 00h-0Fh gives region 0 (main RAM); 10h-1Fh gives 1 (extended RAM);
  - 20h-27h gives 2 (standard planar video); 28h-2Fh gives 3 (extended planar video);
  - 30h-33h gives 4 (read-modify-write video);
  - 34h-37h gives 5 (boot ROM); 38h gives 6 (text video); 39h gives 7 (character generator); 3Ah gives 8 (dictionary ROM);
  - 3Bh gives 10 (unmapped); 3Ch-3Fh gives 9 (communication ROM).
- R7: wait_cnt for each region:
  - regions 0, 1, 5, 8 and 9: 1 on opcode fetch, otherwise 0;
  - regions 2, 3 and 6: 1;
  - regions 4 and 7: 2;
  - region 10: 0.
- R8: fetch_fault is high when mem_req and mem_fetch are both high and the region is a video region (2, 3, 4, 6 or 7).
- R9: stall is high when mem_req is high, the region is a video region, and blank is low.
- R10: In region 10, mem_rdata_out is FFh and mem_we is 0. In all other regions, mem_rdata_out equals mem_rdata_in and mem_we equals mem_req and mem_write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| io_port | input | 1 | 0 selects the index port, 1 selects the data port |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | Block number of the selected window |
| mem_req | input | 1 | Memory cycle active |
| mem_fetch | input | 1 | Cycle is an opcode fetch |
| mem_write | input | 1 | Cycle is a write |
| mem_addr | input | 16 | CPU address |
| blank | input | 1 | Display is in blanking |
| mem_rdata_in | input | 8 | Read data from the store |
| mem_rdata_out | output | 8 | Read data to the CPU |
| mem_we | output | 1 | Write enable to the store |
| phys_block | output | 6 | Translated block number |
| phys_addr | output | 19 | Translated physical address |
| region | output | 4 | Region code |
| wait_cnt | output | 2 | Fixed wait states |
| fetch_fault | output | 1 | Illegal opcode fetch |
| stall | output | 1 | Video access held until blanking |

## Verification
The hardest case to reach is the wrap of the auto-incremented index. Two other cases are also hard: an access through a window loaded by a long run of data-port writes, and the single unmapped block. The unmapped block appears only when software programs that exact value into some window.

The stimulus covers these cases in several ways:
- It reads all eight windows back to back after reset, then reads once more. This shows the wrap and the reset defaults.
- It loads the unmapped block into a chosen window and reads and writes through it.
- It drives random index writes, data writes and reads mixed with accesses. The bench keeps its own copy of the window table and index, so every translation is checked against the programmed state.

// File: rtl/bank_map_unit.sv
module bank_map_unit #(
  parameter int ADDR_W = 16,
  parameter int BLK_W  = 6,
  parameter int WIN_W  = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            io_port,
  input  logic                            io_wr,
  input  logic                            io_rd,
  input  logic [7:0]                      io_wdata,
  output logic [7:0]                      io_rdata,
  input  logic                            mem_req,
  input  logic                            mem_fetch,
  input  logic                            mem_write,
  input  logic [ADDR_W-1:0]               mem_addr,
  input  logic                            blank,
  input  logic [7:0]                      mem_rdata_in,
  output logic [7:0]                      mem_rdata_out,
  output logic                            mem_we,
  output logic [BLK_W-1:0]                phys_block,
  output logic [BLK_W+ADDR_W-WIN_W-1:0]   phys_addr,
  output logic [3:0]                      region,
  output logic [1:0]                      wait_cnt,
  output logic                            fetch_fault,
  output logic                            stall
);
  localparam int NWIN   = 1 << WIN_W;
  localparam int OFS_W  = ADDR_W - WIN_W;
  localparam int BOOT_N = 2;

  localparam logic [3:0] RG_MAIN = 4'd0, RG_EXT = 4'd1, RG_PLN = 4'd2, RG_XPLN = 4'd3,
                         RG_RMW = 4'd4, RG_BOOT = 4'd5, RG_TXT = 4'd6, RG_CHR = 4'd7,
                         RG_DICT = 4'd8, RG_COMM = 4'd9, RG_NONE = 4'd10;

  logic [NWIN-1:0][BLK_W-1:0] map_q;
  logic [WIN_W-1:0]           idx_q;
  logic                       data_acc, data_wr, idx_wr;
  logic [WIN_W-1:0]           win;
  logic                       is_video;

  assign data_acc = io_port & (io_wr | io_rd);
  assign data_wr  = io_port & io_wr;
  assign idx_wr   = ~io_port & io_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      for (int w = 0; w < NWIN; w++)
        map_q[w] <= (w < BOOT_N) ? BLK_W'(6'h34 + w) : BLK_W'(w);
    end else begin
      if (idx_wr)
        idx_q <= io_wdata[WIN_W-1:0];
      else if (data_acc)
        idx_q <= idx_q + 1'b1;
      if (data_wr)
        map_q[idx_q] <= io_wdata[BLK_W-1:0];
    end
  end

  assign io_rdata = 8'(map_q[idx_q]);

  assign win        = mem_addr[ADDR_W-1:OFS_W];
  assign phys_block = map_q[win];
  assign phys_addr  = {phys_block, mem_addr[OFS_W-1:0]};

  always_comb begin
    if      (phys_block <= BLK_W'(6'h0F)) region = RG_MAIN;
    else if (phys_block <= BLK_W'(6'h1F)) region = RG_EXT;
    else if (phys_block <= BLK_W'(6'h27)) region = RG_PLN;
    else if (phys_block <= BLK_W'(6'h2F)) region = RG_XPLN;
    else if (phys_block <= BLK_W'(6'h33)) region = RG_RMW;
    else if (phys_block <= BLK_W'(6'h37)) region = RG_BOOT;
    else if (phys_block == BLK_W'(6'h38)) region = RG_TXT;
    else if (phys_block == BLK_W'(6'h39)) region = RG_CHR;
    else if (phys_block == BLK_W'(6'h3A)) region = RG_DICT;
    else if (phys_block == BLK_W'(6'h3B)) region = RG_NONE;
    else                                  region = RG_COMM;
  end

  always_comb begin
    case (region)
      RG_PLN, RG_XPLN, RG_TXT: wait_cnt = 2'd1;
      RG_RMW, RG_CHR:          wait_cnt = 2'd2;
      RG_NONE:                 wait_cnt = 2'd0;
      default:                 wait_cnt = mem_fetch ? 2'd1 : 2'd0;
    endcase
  end

  assign is_video = (region == RG_PLN) | (region == RG_XPLN) | (region == RG_RMW) |
                    (region == RG_TXT) | (region == RG_CHR);

  assign fetch_fault   = mem_req & mem_fetch & is_video;
  assign stall         = mem_req & is_video & ~blank;
  assign mem_rdata_out = (region == RG_NONE) ? 8'hFF : mem_rdata_in;
  assign mem_we        = mem_req & mem_write & (region != RG_NONE);

  // R2
  idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |=> idx_q == $past(io_wdata[WIN_W-1:0]));

  // R4
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_acc && !idx_wr |=> idx_q == WIN_W'($past(idx_q) + 1'b1));

  // R3
  map_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !io_wr |=> $stable(map_q));

  // R8
  fault_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_fault |-> wait_cnt != 2'd0);

  // R9
  stall_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !blank && mem_req);
endmodule

// File: tb/bank_map_unit_bench.sv
`timescale 1ns/1ps
module bank_map_unit_bench;
  logic clk = 0, rst_n = 0;
  logic io_port = 0, io_wr = 0, io_rd = 0;
  logic [7:0] io_wdata = 0, io_rdata;
  logic mem_req = 0, mem_fetch = 0, mem_write = 0, blank = 0;
  logic [15:0] mem_addr = 0;
  logic [7:0] mem_rdata_in = 0, mem_rdata_out;
  logic mem_we, fetch_fault, stall;
  logic [5:0] phys_block;
  logic [18:0] phys_addr;
  logic [3:0] region;
  logic [1:0] wait_cnt;

  int total = 0, bad = 0;
  bit done = 0;
  logic [5:0] mdl_map [8];
  logic [2:0] mdl_idx;

  always #10 clk = ~clk;

  bank_map_unit u_bank_map_unit (.*);

  function automatic logic [3:0] f_region(input logic [5:0] b);
    if (b <= 6'h0F) return 4'd0;
    if (b <= 6'h1F) return 4'd1;
    if (b <= 6'h27) return 4'd2;
    if (b <= 6'h2F) return 4'd3;
    if (b <= 6'h33) return 4'd4;
    if (b <= 6'h37) return 4'd5;
    case (b)
      6'h38: return 4'd6;
      6'h39: return 4'd7;
      6'h3A: return 4'd8;
      6'h3B: return 4'd10;
      default: return 4'd9;
    endcase
  endfunction

  function automatic bit f_video(input logic [3:0] r);
    return r == 2 || r == 3 || r == 4 || r == 6 || r == 7;
  endfunction

  function automatic logic [1:0] f_wait(input logic [3:0] r, input bit fetch);
    if (r == 2 || r == 3 || r == 6) return 2'd1;
    if (r == 4 || r == 7) return 2'd2;
    if (r == 10) return 2'd0;
    return fetch ? 2'd1 : 2'd0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic io_op(input bit port, input bit wr, input bit rd, input logic [7:0] d);
    @(negedge clk);
    io_port = port; io_wr = wr; io_rd = rd; io_wdata = d;
    #1;
    if (rd && port) chk("R3 read", io_rdata, {2'b00, mdl_map[mdl_idx]});
    @(posedge clk);
    if (wr && !port) mdl_idx = d[2:0];
    else if (port && (wr || rd)) begin
      if (wr) mdl_map[mdl_idx] = d[5:0];
      mdl_idx = mdl_idx + 1'b1;
    end
    @(negedge clk);
    io_wr = 0; io_rd = 0;
  endtask

  task automatic mem_op(input logic [15:0] a, input bit fetch, input bit wr, input bit blk, input logic [7:0] rin);
    logic [5:0] b;
    logic [3:0] r;
    @(negedge clk);
    mem_req = 1; mem_addr = a; mem_fetch = fetch; mem_write = wr; blank = blk; mem_rdata_in = rin;
    #1;
    b = mdl_map[a[15:13]];
    r = f_region(b);
    chk("R5 block", phys_block, b);
    chk("R5 addr", phys_addr, {b, a[12:0]});
    chk("R6 region", region, r);
    chk("R7 wait", wait_cnt, f_wait(r, fetch));
    chk("R8 fault", fetch_fault, fetch && f_video(r));
    chk("R9 stall", stall, f_video(r) && !blk);
    chk("R10 rdata", mem_rdata_out, (r == 10) ? 8'hFF : rin);
    chk("R10 we", mem_we, wr && r != 10);
    @(negedge clk);
    mem_req = 0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1));
    for (int w = 0; w < 8; w++) mdl_map[w] = (w < 2) ? 6'(6'h34 + w) : 6'(w);
    mdl_idx = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset defaults; R4 eight reads wrap back to window 0
    for (int w = 0; w < 8; w++) begin
      @(negedge clk); #1;
      chk("R1 default", io_rdata, {2'b00, (w < 2) ? 6'(6'h34 + w) : 6'(w)});
      io_op(1, 0, 1, 0);
    end
    #1 chk("R4 wrap", io_rdata, 8'h34);
    // R2 upper bits ignored
    io_op(0, 1, 0, 8'hFD);
    #1 chk("R2 index", io_rdata, 8'h05);
    // R3 upper data bits ignored, R4 advance after write
    io_op(1, 1, 0, 8'hE9);
    #1 chk("R4 after write", io_rdata, 8'h06);
    io_op(0, 1, 0, 8'h05);
    #1 chk("R3 store", io_rdata, 8'h29);
    // R4 both strobes advance once
    io_op(1, 1, 1, 8'h38);
    #1 chk("R4 dual strobe", io_rdata, 8'h06);
    // R10 unmapped block
    io_op(0, 1, 0, 8'h03);
    io_op(1, 1, 0, 8'h3B);
    mem_op(16'h6123, 0, 1, 1, 8'h12);
    mem_op(16'h7FFF, 0, 0, 0, 8'h5A);
    // R9 stall vs blank on text video, R8 fetch
    mem_op(16'hA000, 1, 0, 0, 8'h00);
    mem_op(16'hA000, 0, 0, 1, 8'h00);
    mem_op(16'h0000, 1, 0, 0, 8'h33);
    mem_op(16'h0000, 0, 0, 0, 8'h33);
    for (int i = 0; i < 1500; i++) begin
      int k = $urandom_range(0, 9);
      if (k == 0) io_op(0, 1, 0, 8'($urandom));
      else if (k <= 2) io_op(1, 1, 0, 8'($urandom));
      else if (k == 3) io_op(1, 0, 1, 0);
      else mem_op(16'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 8'($urandom));
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule